// File: doc/BRIEF.md
# Unsigned Divider with Status Flag Generation

This block divides one unsigned operand by another of the same width in a single combinational pass. It returns both the quotient and the remainder. It also produces the status flags that an 8-bit controller's divide instruction leaves behind. The surrounding datapath presents the dividend, the divisor and the current flag vector. It then takes the results back in the same cycle, with a fixed propagation delay and no internal state.

Division by zero has a defined outcome. The overflow flag rises and both results are forced to all ones, so downstream logic never sees a value that depends on how the array happens to settle. The main carry flag is cleared in every case. Any nibble-level auxiliary carry bits in the flag vector are passed through untouched. Incoming main carry and overflow values have no influence on any output.

Top module: `divUnit`

## Requirements
- R1: For a nonzero divisor, the quotient output equals the dividend integer-divided by the divisor (floor), DataW bits wide.
- R2: For a nonzero divisor, the remainder output equals the dividend modulo the divisor, and it is strictly less than the divisor.
- R3: The top bit of the carry vector output (bit CarryW-1, the main carry) is 0 for every input combination.
- R4: For a nonzero divisor, the overflow output is 0.
- R5: For a divisor of zero, the overflow output is 1.
- R6: For a divisor of zero, both the quotient and the remainder are all ones.
- R7: Carry vector output bits CarryW-2 down to 0 (the auxiliary carries) equal the same bits of the carry vector input.
- R8: The quotient, the remainder, the carry output top bit and the overflow output are unchanged when only the incoming carry top bit or the incoming overflow value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dividendIn | input | DataW | Unsigned dividend |
| divisorIn | input | DataW | Unsigned divisor |
| carryIn | input | CarryW = (DataW-1)/4+1 | Incoming flag vector, main carry in the top bit |
| ovfIn | input | 1 | Incoming overflow flag (ignored) |
| quotientOut | output | DataW | Quotient, all ones on divide by zero |
| remainderOut | output | DataW | Remainder, all ones on divide by zero |
| carryOut | output | CarryW | Updated flag vector: top bit cleared, lower bits passed through |
| ovfOut | output | 1 | Set only on divide by zero |

## Verification
The assertions sample the outputs only after every input has settled. They assume the operands are driven to known two-state values, and they do not check any behaviour while the inputs are changing. The bench applies each input set half a clock before it samples the results and never drives X or Z onto an input. For DataW = 8 it visits every dividend and divisor pair once, cycling the incoming flag values along the way. It then repeats a spread of operand pairs under all eight incoming flag combinations.

// File: rtl/divPkg.sv
package divPkg;

  // Strobes from the control decode into the arithmetic and flag logic
  typedef struct packed {
    logic zeroDiv;    // divisor is zero
    logic forceOnes;  // override quotient and remainder with all ones
  } divStrobeT;

  function automatic int carryWidth(input int dataW);
    return (dataW - 1) / 4 + 1;
  endfunction

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int DataW = 8
) (
  input  logic [DataW-1:0] divisorIn,
  output divStrobeT        strobe
);

  logic isZero;

  assign isZero          = (divisorIn == '0);
  assign strobe.zeroDiv   = isZero;
  assign strobe.forceOnes = isZero;

endmodule

// File: rtl/divCore.sv
module divCore
  import divPkg::*;
#(
  parameter int DataW = 8
) (
  input  logic [DataW-1:0] dividendIn,
  input  logic [DataW-1:0] divisorIn,
  input  divStrobeT        strobe,
  output logic [DataW-1:0] quotientOut,
  output logic [DataW-1:0] remainderOut
);

  // Partial remainder entering each restoring stage
  logic [DataW-1:0] remStage [0:DataW];
  logic [DataW-1:0] quotRaw;

  assign remStage[0] = '0;

  for (genvar stg = 0; stg < DataW; stg++) begin : gStage
    localparam int BitIdx = DataW - 1 - stg;
    logic [DataW:0]   shifted;
    logic [DataW-1:0] diffLo;
    logic             take;

    assign shifted = {remStage[stg], dividendIn[BitIdx]};
    assign take    = (shifted >= {1'b0, divisorIn});
    // Result fits in DataW bits whenever a subtraction is taken
    assign diffLo  = shifted[DataW-1:0] - divisorIn;

    assign quotRaw[BitIdx]  = take;
    assign remStage[stg+1]  = take ? diffLo : shifted[DataW-1:0];
  end

  assign quotientOut  = strobe.forceOnes ? '1 : quotRaw;
  assign remainderOut = strobe.forceOnes ? '1 : remStage[DataW];

endmodule

// File: rtl/divFlags.sv
module divFlags
  import divPkg::*;
#(
  parameter int DataW = 8
) (
  input  logic [carryWidth(DataW)-1:0] carryIn,
  input  logic                         ovfIn,
  input  divStrobeT                    strobe,
  output logic [carryWidth(DataW)-1:0] carryOut,
  output logic                         ovfOut
);

  localparam int CarryW = carryWidth(DataW);

  // Incoming main carry and overflow are deliberately discarded
  logic unusedFlags;
  assign unusedFlags = ^{carryIn[CarryW-1], ovfIn};

  if (CarryW > 1) begin : gAux
    assign carryOut = {1'b0, carryIn[CarryW-2:0]};
  end else begin : gNoAux
    assign carryOut = 1'b0;
  end

  assign ovfOut = strobe.zeroDiv;

endmodule

// File: rtl/divUnit.sv
module divUnit
  import divPkg::*;
#(
  parameter int DataW  = 8,
  localparam int CarryW = (DataW - 1) / 4 + 1
) (
  input  logic [DataW-1:0]  dividendIn,
  input  logic [DataW-1:0]  divisorIn,
  input  logic [CarryW-1:0] carryIn,
  input  logic              ovfIn,
  output logic [DataW-1:0]  quotientOut,
  output logic [DataW-1:0]  remainderOut,
  output logic [CarryW-1:0] carryOut,
  output logic              ovfOut
);

  divStrobeT strobe;

  divCtrl #(.DataW(DataW)) uCtrl (
    .divisorIn (divisorIn),
    .strobe    (strobe)
  );

  divCore #(.DataW(DataW)) uCore (
    .dividendIn   (dividendIn),
    .divisorIn    (divisorIn),
    .strobe       (strobe),
    .quotientOut  (quotientOut),
    .remainderOut (remainderOut)
  );

  divFlags #(.DataW(DataW)) uFlags (
    .carryIn  (carryIn),
    .ovfIn    (ovfIn),
    .strobe   (strobe),
    .carryOut (carryOut),
    .ovfOut   (ovfOut)
  );

endmodule

// File: rtl/divUnitChecker.sv
module divUnitChecker #(
  parameter int DataW  = 8,
  localparam int CarryW = (DataW - 1) / 4 + 1
) (
  input logic [DataW-1:0]  dividendIn,
  input logic [DataW-1:0]  divisorIn,
  input logic [CarryW-1:0] carryIn,
  input logic              ovfIn,
  input logic [DataW-1:0]  quotientOut,
  input logic [DataW-1:0]  remainderOut,
  input logic [CarryW-1:0] carryOut,
  input logic              ovfOut
);

  logic [2*DataW-1:0] rebuilt;
  logic               unusedOvf;

  assign rebuilt   = ({{DataW{1'b0}}, quotientOut} * {{DataW{1'b0}}, divisorIn})
                   + {{DataW{1'b0}}, remainderOut};
  assign unusedOvf = ovfIn;

  always_comb begin
    if (divisorIn != '0) begin
      AST_QUOT_REBUILD: assert (rebuilt == {{DataW{1'b0}}, dividendIn}); // R1
      AST_REM_BELOW: assert (remainderOut < divisorIn); // R2
      AST_NO_OVERFLOW: assert (ovfOut == 1'b0); // R4
    end else begin
      AST_OVF_ON_ZERO: assert (ovfOut == 1'b1); // R5
      AST_ONES_ON_ZERO: assert (quotientOut == '1 && remainderOut == '1); // R6
    end
    AST_CARRY_CLEAR: assert (carryOut[CarryW-1] == 1'b0); // R3
  end

  if (CarryW > 1) begin : gAuxChk
    always_comb begin
      AST_AUX_PASS: assert (carryOut[CarryW-2:0] == carryIn[CarryW-2:0]); // R7
    end
  end else begin : gNoAuxChk
    logic unusedCarry;
    assign unusedCarry = carryIn[0];
  end

endmodule

bind divUnit divUnitChecker #(.DataW(DataW)) uChk (.*);

// File: tb/tb_divUnit.sv
`timescale 1ns/100ps
module tb_divUnit;

  localparam int DataW  = 8;
  localparam int CarryW = (DataW - 1) / 4 + 1;
  localparam int Span   = 1 << DataW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [DataW-1:0]  dividendIn = '0;
  logic [DataW-1:0]  divisorIn  = '0;
  logic [CarryW-1:0] carryIn    = '0;
  logic              ovfIn      = 1'b0;
  logic [DataW-1:0]  quotientOut, remainderOut;
  logic [CarryW-1:0] carryOut;
  logic              ovfOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  divUnit #(.DataW(DataW)) dut (.*);

  // Behavioural reference with integers
  task automatic checkVec(input int a, input int b, input int flags);
    int expQ, expR, expOv, expCarry;
    @(posedge clk);
    dividendIn = a[DataW-1:0];
    divisorIn  = b[DataW-1:0];
    carryIn    = flags[CarryW-1:0];
    ovfIn      = flags[CarryW];
    @(negedge clk);
    if (b != 0) begin
      expQ = a / b; expR = a % b; expOv = 0;
    end else begin
      expQ = Span - 1; expR = Span - 1; expOv = 1;
    end
    expCarry = flags & ((1 << (CarryW - 1)) - 1);
    testsRun++;
    if (int'(quotientOut) != expQ) begin
      testsFailed++;
      $display("FAIL %s quotient a=%0d b=%0d got %0d exp %0d",
               (b != 0) ? "R1" : "R6", a, b, quotientOut, expQ);
    end else if (int'(remainderOut) != expR) begin
      testsFailed++;
      $display("FAIL %s remainder a=%0d b=%0d got %0d exp %0d",
               (b != 0) ? "R2" : "R6", a, b, remainderOut, expR);
    end else if (int'(ovfOut) != expOv) begin
      testsFailed++;
      $display("FAIL %s overflow a=%0d b=%0d got %0d exp %0d",
               (b != 0) ? "R4" : "R5", a, b, ovfOut, expOv);
    end else if (int'(carryOut) != expCarry) begin
      testsFailed++;
      $display("FAIL R3/R7 carry flags=%0d got %0d exp %0d", flags, carryOut, expCarry);
    end
  endtask

  // R8: same operands, every incoming flag value, results must not move
  task automatic checkIgnore(input int a, input int b);
    logic [DataW-1:0] q0, r0;
    logic             c0, o0;
    for (int f = 0; f < (1 << (CarryW + 1)); f++) begin
      checkVec(a, b, f);
      if (f == 0) begin
        q0 = quotientOut; r0 = remainderOut; c0 = carryOut[CarryW-1]; o0 = ovfOut;
      end else begin
        testsRun++;
        if (quotientOut != q0 || remainderOut != r0 ||
            carryOut[CarryW-1] != c0 || ovfOut != o0) begin
          testsFailed++;
          $display("FAIL R8 a=%0d b=%0d flags=%0d got q=%0d r=%0d exp q=%0d r=%0d",
                   a, b, f, quotientOut, remainderOut, q0, r0);
        end
      end
    end
  endtask

  initial begin
    #1;
    // Initial state: all-zero inputs, a divide by zero
    testsRun++;
    if (ovfOut !== 1'b1 || quotientOut !== '1 || carryOut !== '0) begin
      testsFailed++;
      $display("FAIL R5 initial ovf=%0b q=%0d exp ovf=1 q=%0d", ovfOut, quotientOut, Span - 1);
    end
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Corner cases: R1 R2 R5 R6
    checkVec(Span - 1, 1, 0);
    checkVec(Span - 1, Span - 1, 7);
    checkVec(0, Span - 1, 3);
    checkVec(5, 0, 7);
    checkVec(0, 0, 0);
    checkVec(Span - 2, Span - 1, 2);
    // Exhaustive sweep with varying flags (R1..R7)
    for (int a = 0; a < Span; a++)
      for (int b = 0; b < Span; b++)
        checkVec(a, b, (a ^ (b >> 3)) & ((1 << (CarryW + 1)) - 1));
    // Flag independence (R8)
    for (int k = 0; k < 64; k++)
      checkIgnore((k * 37 + 11) % Span, (k * 13) % Span);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule